// File: doc/BRIEF.md
# Software Interrupt Pending Register with Level Masking

This block holds a word of pending software interrupts and a small processor interrupt level register, and turns the two into one interrupt request line per pending bit. Software changes the pending word in three ways: it can replace the whole word, OR bits into it through a set alias, or remove bits through a clear alias. A compare-match pulse from the system tick timer sets the timer bit in hardware, independently of software.

The request vector is masked by the level. The lowest bit and the timer bit share a fixed threshold: they request only while the level is below 14. Every other bit requests only when its index is strictly greater than the level. The requests come from registered state through combinational gating, so a write to the word, to either alias or to the level shows in the requests on the clock after the write. A combinational read port returns the pending word, the level, or zero for the two write-only aliases.

Top module: `softirq_reg`

## Requirements
- R1: After reset the pending word reads 0, the level reads 15 and every request line is low.
- R2: A write with select 0 (word) replaces the whole pending word with the written data from the next clock.
- R3: A write with select 1 (set alias) ORs the written data into the pending word and leaves the other bits unchanged.
- R4: A write with select 2 (clear alias) clears every pending bit that is 1 in the written data and leaves the other bits unchanged.
- R5: Request bits 0 and 16 are high only when the matching pending bit is set and the level is below 14.
- R6: Each request bit from 1 to 15 is high only when its pending bit is set and its index is strictly greater than the level.
- R7: A timer-match pulse sets pending bit 16 and keeps all other bits; when it coincides with a software write, the write result is formed first and bit 16 is then forced to 1.
- R8: The read port returns the pending word for select 0, the level zero-extended in bits 3:0 for select 3, and zero for selects 1 and 2.
- R9: A write with select 3 loads the level from data bits 3:0, and the request vector reflects a new level or word on the next clock with no further delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_sel | input | 2 | Write target: 0 word, 1 set alias, 2 clear alias, 3 level |
| wr_data | input | 17 | Write data |
| timer_hit | input | 1 | Tick timer compare-match pulse, sets bit 16 |
| rd_sel | input | 2 | Read target, same encoding as wr_sel |
| rd_data | output | 17 | Read data |
| irq_req | output | 17 | Per-bit masked interrupt requests |

## Verification
The properties assume the select inputs are always one of the four defined codes and that the inputs are stable around the rising edge; with a two-bit select every code is defined, so only the timing assumption is real. The clear and direct-write properties exclude cycles with a timer pulse, because the timer may legally re-set bit 16 in the same cycle. The stimulus drives all inputs on the falling edge, covers timer pulses both alone and coincident with each write kind, and sweeps the level across all sixteen values against a full pending word.

// File: rtl/softirq_pkg.sv
package softirq_pkg;

    // Register selector shared by the write and read ports
    typedef enum logic [1:0] {
        SEL_WORD  = 2'd0,
        SEL_SET   = 2'd1,
        SEL_CLR   = 2'd2,
        SEL_LEVEL = 2'd3
    } reg_sel_e;

    localparam int DEF_WORD_W    = 17;
    localparam int DEF_LVL_W     = 4;
    localparam int DEF_THRESH    = 14;
    localparam int DEF_LEVEL_RST = 15;

endpackage

// File: rtl/softirq_word.sv
module softirq_word
    import softirq_pkg::*;
#(
    parameter int WORD_W    = DEF_WORD_W,
    parameter int TIMER_BIT = DEF_WORD_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              timer_hit,
    output logic [WORD_W-1:0] word_q
);

    localparam logic [WORD_W-1:0] TIMER_MASK = WORD_W'(1) << TIMER_BIT;

    logic [WORD_W-1:0] sw_next;
    logic [WORD_W-1:0] word_d;

    // Software result first, then the timer bit on top
    always_comb begin
        sw_next = word_q;
        if (wr_en) begin
            unique case (wr_sel)
                SEL_WORD:  sw_next = wr_data;
                SEL_SET:   sw_next = word_q | wr_data;
                SEL_CLR:   sw_next = word_q & ~wr_data;
                SEL_LEVEL: sw_next = word_q;
                default:   sw_next = word_q;
            endcase
        end
        word_d = timer_hit ? (sw_next | TIMER_MASK) : sw_next;
    end

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= word_d;
    end

endmodule

// File: rtl/softirq_level.sv
module softirq_level
    import softirq_pkg::*;
#(
    parameter int WORD_W    = DEF_WORD_W,
    parameter int LVL_W     = DEF_LVL_W,
    parameter int LEVEL_RST = DEF_LEVEL_RST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic [LVL_W-1:0]  level_q
);

    logic load;
    assign load = wr_en && (wr_sel == SEL_LEVEL);

    always_ff @(posedge clk) begin
        if (rst)       level_q <= LVL_W'(LEVEL_RST);
        else if (load) level_q <= wr_data[LVL_W-1:0];
    end

endmodule

// File: rtl/softirq_gate.sv
module softirq_gate #(
    parameter int WORD_W    = 17,
    parameter int LVL_W     = 4,
    parameter int THRESH    = 14,
    parameter int TIMER_BIT = WORD_W - 1
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [LVL_W-1:0]  level_i,
    output logic [WORD_W-1:0] req_o
);

    localparam int CMP_W = LVL_W + 6;

    logic [CMP_W-1:0] level_ext;
    logic             below_fixed;

    assign level_ext   = CMP_W'(level_i);
    assign below_fixed = level_ext < CMP_W'(THRESH);

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        if (i == 0 || i == TIMER_BIT) begin : g_fixed
            assign req_o[i] = word_i[i] && below_fixed;
        end else begin : g_indexed
            assign req_o[i] = word_i[i] && (CMP_W'(i) > level_ext);
        end
    end

endmodule

// File: rtl/softirq_reg.sv
module softirq_reg
    import softirq_pkg::*;
#(
    parameter int WORD_W    = DEF_WORD_W,
    parameter int LVL_W     = DEF_LVL_W,
    parameter int THRESH    = DEF_THRESH,
    parameter int LEVEL_RST = DEF_LEVEL_RST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              timer_hit,
    input  logic [1:0]        rd_sel,
    output logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] irq_req
);

    localparam int TIMER_BIT = WORD_W - 1;

    reg_sel_e          wsel;
    reg_sel_e          rsel;
    logic [WORD_W-1:0] word_q;
    logic [LVL_W-1:0]  level_q;

    assign wsel = reg_sel_e'(wr_sel);
    assign rsel = reg_sel_e'(rd_sel);

    softirq_word #(.WORD_W(WORD_W), .TIMER_BIT(TIMER_BIT)) u_word (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wsel),
        .wr_data   (wr_data),
        .timer_hit (timer_hit),
        .word_q    (word_q)
    );

    softirq_level #(.WORD_W(WORD_W), .LVL_W(LVL_W), .LEVEL_RST(LEVEL_RST)) u_level (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wsel),
        .wr_data (wr_data),
        .level_q (level_q)
    );

    softirq_gate #(.WORD_W(WORD_W), .LVL_W(LVL_W), .THRESH(THRESH),
                   .TIMER_BIT(TIMER_BIT)) u_gate (
        .word_i  (word_q),
        .level_i (level_q),
        .req_o   (irq_req)
    );

    // Aliases are write-only and read as zero
    always_comb begin
        unique case (rsel)
            SEL_WORD:  rd_data = word_q;
            SEL_LEVEL: rd_data = WORD_W'(level_q);
            SEL_SET:   rd_data = '0;
            SEL_CLR:   rd_data = '0;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/softirq_reg_chk.sv
module softirq_reg_chk #(
    parameter int WORD_W = 17,
    parameter int LVL_W  = 4,
    parameter int THRESH = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [WORD_W-1:0] wr_data,
    input logic              timer_hit,
    input logic [1:0]        rd_sel,
    input logic [WORD_W-1:0] rd_data,
    input logic [WORD_W-1:0] irq_req,
    input logic [WORD_W-1:0] word_q,
    input logic [LVL_W-1:0]  level_q
);

    assert_direct_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0 && !timer_hit) |=> (word_q == $past(wr_data)));

    assert_set_alias_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd1) |=> ((word_q & $past(wr_data)) == $past(wr_data)));

    assert_clear_alias_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd2 && !timer_hit) |=> ((word_q & $past(wr_data)) == '0));

    assert_fixed_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (irq_req[0] || irq_req[WORD_W-1]) |-> (int'(level_q) < THRESH));

    assert_req_needs_pending_R6: assert property (@(posedge clk) disable iff (rst)
        ((irq_req & ~word_q) == '0));

    assert_timer_sets_R7: assert property (@(posedge clk) disable iff (rst)
        timer_hit |=> word_q[WORD_W-1]);

    assert_alias_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_sel == 2'd1 || rd_sel == 2'd2) |-> (rd_data == '0));

    assert_level_load_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd3) |=> (level_q == $past(wr_data[LVL_W-1:0])));

endmodule

bind softirq_reg softirq_reg_chk #(.WORD_W(WORD_W), .LVL_W(LVL_W), .THRESH(THRESH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .timer_hit (timer_hit),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data),
    .irq_req   (irq_req),
    .word_q    (word_q),
    .level_q   (level_q)
);

// File: tb/tb_softirq_reg.sv
module tb_softirq_reg;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [16:0] wr_data;
    logic        timer_hit;
    logic [1:0]  rd_sel;
    logic [16:0] rd_data;
    logic [16:0] irq_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [16:0] m_word;
    int          m_lvl;

    always #5 clk = ~clk;

    softirq_reg dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .timer_hit (timer_hit),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .irq_req   (irq_req)
    );

    function automatic logic [16:0] exp_req();
        logic [16:0] r = '0;
        for (int i = 0; i < 17; i++) begin
            if (i == 0 || i == 16) r[i] = m_word[i] && (m_lvl < 14);
            else                   r[i] = m_word[i] && (i > m_lvl);
        end
        return r;
    endfunction

    function automatic logic [16:0] exp_rd(input logic [1:0] s);
        if (s == 2'd0) return m_word;
        if (s == 2'd3) return 17'(m_lvl);
        return '0;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [16:0] act, input logic [16:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive at the falling edge, advance the model at the rising edge,
    // compare at the next falling edge.
    task automatic step(input logic en, input logic [1:0] sel, input logic [16:0] data,
                        input logic tmr, input logic [1:0] rsel, input string tag);
        wr_en = en; wr_sel = sel; wr_data = data; timer_hit = tmr; rd_sel = rsel;
        @(posedge clk);
        if (en) begin
            case (sel)
                2'd0: m_word = data;
                2'd1: m_word = m_word | data;
                2'd2: m_word = m_word & ~data;
                default: m_lvl = int'(data[3:0]);
            endcase
        end
        if (tmr) m_word[16] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; timer_hit = 1'b0;
        check(tag, "irq_req", irq_req, exp_req());
        check(tag, "rd_data", rd_data, exp_rd(rsel));
    endtask

    task automatic idle_read(input logic [1:0] rsel, input string tag);
        step(1'b0, 2'd0, '0, 1'b0, rsel, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0; timer_hit = 1'b0; rd_sel = '0;
        m_word = '0; m_lvl = 15;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1", "irq_req", irq_req, 17'h0);
        idle_read(2'd0, "R1");
        idle_read(2'd3, "R1");

        // R2 direct write, level 15 masks everything
        step(1'b1, 2'd0, 17'h1FFFF, 1'b0, 2'd0, "R2");
        step(1'b1, 2'd0, 17'h0A5A5, 1'b0, 2'd0, "R2");
        // R8 reads
        idle_read(2'd1, "R8");
        idle_read(2'd2, "R8");
        idle_read(2'd3, "R8");

        // R9/R5/R6 level changes
        step(1'b1, 2'd0, 17'h1FFFF, 1'b0, 2'd0, "R2");
        step(1'b1, 2'd3, 17'h1FFF0 | 17'd13, 1'b0, 2'd3, "R9");
        step(1'b1, 2'd3, 17'd14, 1'b0, 2'd0, "R5");
        step(1'b1, 2'd3, 17'd0, 1'b0, 2'd0, "R6");

        // R4 clear alias, R3 set alias
        step(1'b1, 2'd2, 17'h00F0F, 1'b0, 2'd0, "R4");
        step(1'b1, 2'd2, 17'h10001, 1'b0, 2'd0, "R4");
        step(1'b1, 2'd1, 17'h00003, 1'b0, 2'd1, "R3");
        idle_read(2'd0, "R3");
        step(1'b1, 2'd1, 17'h10000, 1'b0, 2'd0, "R3");

        // R7 timer alone and coincident with writes
        step(1'b1, 2'd2, 17'h10000, 1'b0, 2'd0, "R4");
        step(1'b0, 2'd0, '0, 1'b1, 2'd0, "R7");
        step(1'b1, 2'd2, 17'h1FFFF, 1'b1, 2'd0, "R7");
        step(1'b1, 2'd0, 17'h00022, 1'b1, 2'd0, "R7");
        step(1'b1, 2'd1, 17'h00400, 1'b1, 2'd0, "R7");
        step(1'b1, 2'd3, 17'd7, 1'b1, 2'd3, "R7");

        // R5/R6/R9 sweep over every level with a full word
        step(1'b1, 2'd0, 17'h1FFFF, 1'b0, 2'd0, "R2");
        for (int l = 0; l < 16; l++) begin
            step(1'b1, 2'd3, 17'(l), 1'b0, 2'd3, "R6");
        end
        step(1'b1, 2'd0, 17'h10001, 1'b0, 2'd0, "R5");
        for (int l = 12; l < 16; l++) begin
            step(1'b1, 2'd3, 17'(l), 1'b0, 2'd0, "R5");
        end

        // R1 reset again mid-run
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_word = '0; m_lvl = 15;
        check("R1", "irq_req", irq_req, 17'h0);
        idle_read(2'd0, "R1");
        idle_read(2'd3, "R1");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule